// File: doc/BRIEF.md
# Deadtime Distortion Correction Selector

This block sits next to a complementary PWM generator with three output pairs. Each pair has two candidate duty values: an even one and an odd one. For every PWM cycle the block chooses which of the two values the pair uses. The choice is a single polarity bit per pair. That bit can be fixed at zero, taken from polarity bits that software writes, or taken from current-status inputs. The current-status inputs are captured either while both switches of the pair are off, which is during deadtime, or at a fixed phase marker of the counter.

Software writes the polarity bits and a two-bit correction mode into a buffer. The buffer can be read back at any time, and a read returns the buffered contents. The buffered values move into effect only on the load-cycle strobe, so a selection never changes partway through a PWM cycle. Sampled current-status values follow the same path. They collect in a shadow register and are promoted on the strobe. The chosen duty value for each pair is presented on a registered output.

Top module: `dtc_sel`

## Requirements
- R1: After synchronous reset, the buffered polarity bits, the active polarity bits and the active mode are all zero, and the duty outputs read zero until the first clock after reset, when they show the even values.
- R2: Pair k outputs value 2k when its active polarity bit is 0 and value 2k+1 when it is 1. The output is registered and reflects the values and the selection one clock later.
- R3: A write (`cfg_we` high) stores `cfg_pol` and `cfg_mode` into the buffer. The readback ports show the written contents from the next clock onward, even while a different selection is in effect.
- R4: The buffered polarity bits and mode do not affect the active selection or the sampling until a cycle with `load_stb` high. Without the strobe, the active bits and active mode stay unchanged.
- R5: Mode 00 selects no correction. A strobe with mode 00 buffered clears the active polarity bits, so every pair uses its even value.
- R6: Mode 01 selects manual correction. A strobe with mode 01 buffered copies the buffered polarity bits into the active bits.
- R7: While mode 10 is active, pair k captures `cs_in[k]` on each clock where both `top_on[k]` and `bot_on[k]` are low. When either output is on, which is always the case at 0% or 100% duty, the shadow bit keeps its previous value.
- R8: While mode 11 is active, all pairs capture `cs_in` on a clock with `mid_mark` high if `center_aln` is 1, or with `end_mark` high if `center_aln` is 0. Capture happens regardless of the output states. The other marker is ignored.
- R9: A strobe with mode 10 or 11 buffered copies the shadow of sampled current-status bits into the active polarity bits. In modes 00 and 01 the shadow is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| val_in | input | 2*NPAIR*DW | Candidate duty values; value j is at bits [j*DW +: DW] |
| cfg_we | input | 1 | Write strobe for the polarity/mode buffer |
| cfg_pol | input | NPAIR | Polarity bits to buffer, bit k for pair k |
| cfg_mode | input | 2 | Correction mode to buffer (00 none, 01 manual, 10 deadtime sample, 11 phase sample) |
| cs_in | input | NPAIR | Current-status inputs, bit k for pair k |
| mid_mark | input | 1 | Counter at half cycle (center-aligned) |
| end_mark | input | 1 | Counter at end of cycle (edge-aligned) |
| center_aln | input | 1 | 1 = center-aligned counting, 0 = edge-aligned |
| load_stb | input | 1 | Load-cycle strobe that promotes buffered and sampled bits |
| top_on | input | NPAIR | Top switch state per pair |
| bot_on | input | NPAIR | Bottom switch state per pair |
| duty_out | output | NPAIR*DW | Selected duty value; pair k at bits [k*DW +: DW] |
| rd_pol | output | NPAIR | Readback of buffered polarity bits |
| rd_mode | output | 2 | Readback of buffered mode |

## Verification
Several rules are checked by the bound checker on every clock. It checks the readback after a write and that the active bits and mode hold between strobes. It also checks that the active bits are zero whenever mode 00 is active, that the shadow holds when sampling is not allowed, and that each duty output follows the previous cycle's selection. Other effects appear only over a sequence of cycles: a manual pattern reaching the outputs after a strobe, a deadtime capture surviving a stretch of 100% duty, and the choice between the half-cycle and end-of-cycle markers. The bench's directed scenarios and its per-cycle reference model cover those.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'b00,
    MODE_MANUAL = 2'b01,
    MODE_DTSAMP = 2'b10,
    MODE_PHSAMP = 2'b11
  } corr_mode_e;

  function automatic logic mode_samples(input corr_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/dtc_cfg_regs.sv
module dtc_cfg_regs
  import dtc_pkg::*;
#(
  parameter int NPAIR = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [NPAIR-1:0] cfg_pol,
  input  logic [1:0]       cfg_mode,
  input  logic             load_stb,
  input  logic [NPAIR-1:0] shadow,
  output logic [NPAIR-1:0] buf_pol,
  output corr_mode_e       buf_mode,
  output logic [NPAIR-1:0] act_pol,
  output corr_mode_e       act_mode
);

  // software-visible buffer
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_pol  <= '0;
      buf_mode <= MODE_NONE;
    end else if (cfg_we) begin
      buf_pol  <= cfg_pol;
      buf_mode <= corr_mode_e'(cfg_mode);
    end
  end

  // selection promoted on the load strobe only
  logic [NPAIR-1:0] next_pol;

  always_comb begin
    unique case (buf_mode)
      MODE_NONE:   next_pol = '0;
      MODE_MANUAL: next_pol = buf_pol;
      default:     next_pol = shadow;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_pol  <= '0;
      act_mode <= MODE_NONE;
    end else if (load_stb) begin
      act_pol  <= next_pol;
      act_mode <= buf_mode;
    end
  end

endmodule

// File: rtl/dtc_sampler.sv
module dtc_sampler
  import dtc_pkg::*;
#(
  parameter int NPAIR = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  corr_mode_e       act_mode,
  input  logic [NPAIR-1:0] cs_in,
  input  logic             mid_mark,
  input  logic             end_mark,
  input  logic             center_aln,
  input  logic [NPAIR-1:0] top_on,
  input  logic [NPAIR-1:0] bot_on,
  output logic [NPAIR-1:0] shadow
);

  logic phase_hit;
  assign phase_hit = center_aln ? mid_mark : end_mark;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    logic cap;
    always_comb begin
      unique case (act_mode)
        MODE_DTSAMP: cap = ~top_on[k] & ~bot_on[k];
        MODE_PHSAMP: cap = phase_hit;
        default:     cap = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst)      shadow[k] <= 1'b0;
      else if (cap) shadow[k] <= cs_in[k];
    end
  end

endmodule

// File: rtl/dtc_duty_mux.sv
module dtc_duty_mux #(
  parameter int NPAIR = 3,
  parameter int DW    = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*NPAIR*DW-1:0] val_in,
  input  logic [NPAIR-1:0]      sel,
  output logic [NPAIR*DW-1:0]   duty_out
);

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    localparam int EVEN = 2 * k;
    localparam int ODD  = 2 * k + 1;
    always_ff @(posedge clk) begin
      if (rst)
        duty_out[k*DW +: DW] <= '0;
      else
        duty_out[k*DW +: DW] <= sel[k] ? val_in[ODD*DW +: DW]
                                       : val_in[EVEN*DW +: DW];
    end
  end

endmodule

// File: rtl/dtc_sel.sv
module dtc_sel
  import dtc_pkg::*;
#(
  parameter int NPAIR = 3,
  parameter int DW    = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*NPAIR*DW-1:0] val_in,
  input  logic                  cfg_we,
  input  logic [NPAIR-1:0]      cfg_pol,
  input  logic [1:0]            cfg_mode,
  input  logic [NPAIR-1:0]      cs_in,
  input  logic                  mid_mark,
  input  logic                  end_mark,
  input  logic                  center_aln,
  input  logic                  load_stb,
  input  logic [NPAIR-1:0]      top_on,
  input  logic [NPAIR-1:0]      bot_on,
  output logic [NPAIR*DW-1:0]   duty_out,
  output logic [NPAIR-1:0]      rd_pol,
  output logic [1:0]            rd_mode
);

  logic [NPAIR-1:0] shadow;
  logic [NPAIR-1:0] buf_pol;
  logic [NPAIR-1:0] act_pol;
  corr_mode_e       buf_mode;
  corr_mode_e       act_mode;

  dtc_cfg_regs #(.NPAIR(NPAIR)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_pol(cfg_pol), .cfg_mode(cfg_mode),
    .load_stb(load_stb), .shadow(shadow),
    .buf_pol(buf_pol), .buf_mode(buf_mode),
    .act_pol(act_pol), .act_mode(act_mode)
  );

  dtc_sampler #(.NPAIR(NPAIR)) u_samp (
    .clk(clk), .rst(rst), .act_mode(act_mode),
    .cs_in(cs_in), .mid_mark(mid_mark), .end_mark(end_mark),
    .center_aln(center_aln), .top_on(top_on), .bot_on(bot_on),
    .shadow(shadow)
  );

  dtc_duty_mux #(.NPAIR(NPAIR), .DW(DW)) u_mux (
    .clk(clk), .rst(rst), .val_in(val_in), .sel(act_pol),
    .duty_out(duty_out)
  );

  assign rd_pol  = buf_pol;
  assign rd_mode = buf_mode;

endmodule

// File: rtl/dtc_sel_chk.sv
module dtc_sel_chk #(
  parameter int NPAIR = 3,
  parameter int DW    = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic [2*NPAIR*DW-1:0] val_in,
  input logic                  cfg_we,
  input logic [NPAIR-1:0]      cfg_pol,
  input logic [1:0]            cfg_mode,
  input logic                  load_stb,
  input logic [NPAIR-1:0]      top_on,
  input logic [NPAIR-1:0]      bot_on,
  input logic [NPAIR*DW-1:0]   duty_out,
  input logic [NPAIR-1:0]      rd_pol,
  input logic [1:0]            rd_mode,
  input logic [NPAIR-1:0]      act_pol,
  input logic [1:0]            act_mode,
  input logic [NPAIR-1:0]      shadow
);

  // R3: readback follows a write on the next clock
  a_r3_readback: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (rd_pol == $past(cfg_pol)) && (rd_mode == $past(cfg_mode)));

  // R4: no strobe, no change to the active selection
  a_r4_hold_active: assert property (@(posedge clk) disable iff (rst)
    !load_stb |=> $stable(act_pol) && $stable(act_mode));

  // R5: mode 00 in effect means all-even selection
  a_r5_none_even: assert property (@(posedge clk) disable iff (rst)
    (act_mode == 2'b00) |-> (act_pol == '0));

  // R9: no sampling outside modes 10 and 11
  a_r9_shadow_idle: assert property (@(posedge clk) disable iff (rst)
    (act_mode[1] == 1'b0) |=> $stable(shadow));

  for (genvar k = 0; k < NPAIR; k++) begin : g_k
    // R7: a pair with a switch on keeps its shadow bit in deadtime mode
    a_r7_no_cap_when_on: assert property (@(posedge clk) disable iff (rst)
      (act_mode == 2'b10 && (top_on[k] || bot_on[k])) |=> $stable(shadow[k]));

    // R2: output follows the previous cycle's selection
    a_r2_duty_sel: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> duty_out[k*DW +: DW] ==
        ($past(act_pol[k]) ? $past(val_in[(2*k+1)*DW +: DW])
                           : $past(val_in[(2*k)*DW +: DW])));
  end

endmodule

bind dtc_sel dtc_sel_chk #(.NPAIR(NPAIR), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .val_in(val_in), .cfg_we(cfg_we),
  .cfg_pol(cfg_pol), .cfg_mode(cfg_mode), .load_stb(load_stb),
  .top_on(top_on), .bot_on(bot_on), .duty_out(duty_out),
  .rd_pol(rd_pol), .rd_mode(rd_mode), .act_pol(act_pol),
  .act_mode(act_mode), .shadow(shadow)
);

// File: tb/dtc_sel_tb_top.sv
module dtc_sel_tb_top;
  localparam int NPAIR = 3;
  localparam int DW    = 16;
  localparam int NV    = 2 * NPAIR;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NV*DW-1:0] val_in = '0;
  logic cfg_we = 0;
  logic [NPAIR-1:0] cfg_pol = '0;
  logic [1:0] cfg_mode = '0;
  logic [NPAIR-1:0] cs_in = '0;
  logic mid_mark = 0, end_mark = 0, center_aln = 1, load_stb = 0;
  logic [NPAIR-1:0] top_on = '0, bot_on = '0;
  logic [NPAIR*DW-1:0] duty_out;
  logic [NPAIR-1:0] rd_pol;
  logic [1:0] rd_mode;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dtc_sel #(.NPAIR(NPAIR), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .val_in(val_in), .cfg_we(cfg_we),
    .cfg_pol(cfg_pol), .cfg_mode(cfg_mode), .cs_in(cs_in),
    .mid_mark(mid_mark), .end_mark(end_mark), .center_aln(center_aln),
    .load_stb(load_stb), .top_on(top_on), .bot_on(bot_on),
    .duty_out(duty_out), .rd_pol(rd_pol), .rd_mode(rd_mode)
  );

  // behavioural reference: buffer, active selection, shadow, output
  logic [NPAIR-1:0] m_bpol, m_apol, m_shd;
  logic [1:0]       m_bmode, m_amode;
  logic [DW-1:0]    m_duty [NPAIR];

  always @(posedge clk) begin
    if (rst) begin
      m_bpol <= '0; m_apol <= '0; m_shd <= '0;
      m_bmode <= 2'b00; m_amode <= 2'b00;
      for (int k = 0; k < NPAIR; k++) m_duty[k] <= '0;
    end else begin
      for (int k = 0; k < NPAIR; k++) begin
        m_duty[k] <= m_apol[k] ? val_in[(2*k+1)*DW +: DW] : val_in[2*k*DW +: DW];
        if (m_amode == 2'b10 && !top_on[k] && !bot_on[k]) m_shd[k] <= cs_in[k];
        if (m_amode == 2'b11 && (center_aln ? mid_mark : end_mark)) m_shd[k] <= cs_in[k];
      end
      if (load_stb) begin
        m_amode <= m_bmode;
        m_apol  <= (m_bmode == 2'b00) ? '0 : (m_bmode == 2'b01) ? m_bpol : m_shd;
      end
      if (cfg_we) begin
        m_bpol <= cfg_pol; m_bmode <= cfg_mode;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R2 output, R3 readback)
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      for (int k = 0; k < NPAIR; k++)
        chk("R2 duty vs model", 32'(duty_out[k*DW +: DW]), 32'(m_duty[k]));
      chk("R3 readback vs model", {27'd0, rd_mode, rd_pol}, {27'd0, m_bmode, m_bpol});
    end
  end

  function automatic logic [DW-1:0] vv(input int j);
    return val_in[j*DW +: DW];
  endfunction

  task automatic expect_sel(input string tag, input logic [NPAIR-1:0] s);
    for (int k = 0; k < NPAIR; k++)
      chk(tag, 32'(duty_out[k*DW +: DW]), 32'(s[k] ? vv(2*k+1) : vv(2*k)));
  endtask

  task automatic wr(input logic [NPAIR-1:0] p, input logic [1:0] m);
    @(negedge clk); cfg_we = 1; cfg_pol = p; cfg_mode = m;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic strobe();
    @(negedge clk); load_stb = 1;
    @(negedge clk); load_stb = 0;
    @(negedge clk);
  endtask

  task automatic pulse_mark(input bit mid, input logic [NPAIR-1:0] cs);
    @(negedge clk); cs_in = cs; mid_mark = mid; end_mark = !mid;
    @(negedge clk); mid_mark = 0; end_mark = 0; cs_in = ~cs;
  endtask

  initial begin
    for (int j = 0; j < NV; j++) val_in[j*DW +: DW] = DW'(16'h1100 * (j + 1) + j);
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 duty zero in reset", 32'(duty_out), 32'd0);
    chk("R1 readback zero", {30'd0, rd_mode}, 32'd0);
    rst = 0;
    @(negedge clk);
    cmp_on = 1;
    expect_sel("R1 even after reset", 3'b000);

    // R3/R4: buffered write, not yet in effect
    wr(3'b101, 2'b01);
    chk("R3 rd_pol", 32'(rd_pol), 32'h5);
    chk("R3 rd_mode", 32'(rd_mode), 32'h1);
    repeat (3) @(negedge clk);
    expect_sel("R4 no effect before strobe", 3'b000);
    // R6: manual
    strobe();
    expect_sel("R6 manual after strobe", 3'b101);
    // R3: readback shows buffer, not active
    wr(3'b010, 2'b01);
    chk("R3 buffered not active", 32'(rd_pol), 32'h2);
    expect_sel("R4 active unchanged", 3'b101);
    // R5: mode none
    wr(3'b111, 2'b00);
    strobe();
    expect_sel("R5 none forces even", 3'b000);

    // R7: deadtime sampling
    wr(3'b000, 2'b10);
    strobe();
    @(negedge clk);
    top_on = 3'b010; bot_on = 3'b100; cs_in = 3'b111;
    repeat (3) @(negedge clk);
    strobe();
    expect_sel("R7 captured only where both off", 3'b001);
    top_on = 3'b111; bot_on = 3'b000; cs_in = 3'b000;  // 100% duty
    repeat (4) @(negedge clk);
    strobe();
    expect_sel("R7 held through full duty", 3'b001);

    // R8: phase sampling, center-aligned
    wr(3'b000, 2'b11);
    strobe();                       // shadow 001 promoted (R9)
    expect_sel("R9 shadow promoted on mode change", 3'b001);
    center_aln = 1;
    pulse_mark(0, 3'b011);          // end marker ignored
    strobe();
    expect_sel("R8 end marker ignored when centered", 3'b001);
    pulse_mark(1, 3'b110);
    strobe();
    expect_sel("R8 mid marker captures", 3'b110);
    center_aln = 0;
    pulse_mark(1, 3'b000);          // mid ignored
    pulse_mark(0, 3'b010);
    strobe();
    expect_sel("R8 edge-aligned end capture", 3'b010);

    // R9: shadow untouched in manual mode
    wr(3'b100, 2'b01);
    strobe();
    expect_sel("R9 manual overrides shadow", 3'b100);
    cs_in = 3'b111; top_on = '0; bot_on = '0;
    repeat (3) @(negedge clk);
    wr(3'b000, 2'b10);
    strobe();
    expect_sel("R9 shadow kept while manual", 3'b010);

    // mixed random traffic checked by the model every cycle (R2)
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cfg_we = ($urandom % 7) == 0; cfg_pol = NPAIR'($urandom); cfg_mode = 2'($urandom);
      load_stb = ($urandom % 9) == 0; cs_in = NPAIR'($urandom);
      mid_mark = ($urandom % 5) == 0; end_mark = ($urandom % 5) == 0;
      center_aln = ($urandom % 2) == 0;
      top_on = NPAIR'($urandom); bot_on = NPAIR'($urandom);
      if ((i % 17) == 0) val_in[($urandom % NV)*DW +: DW] = DW'($urandom);
    end
    @(negedge clk);
    cfg_we = 0; load_stb = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog R1-path: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule